// File: doc/BRIEF.md
# Counter-Based PWM Driver for an RC-Filter DAC

This block turns an unsigned data word into a pulse train whose duty cycle follows the word. A low-pass RC network outside the chip averages the pulse train into an analog level, so the block and the filter together form a simple DAC. A typical use is as the reference DAC of a successive-approximation converter, where the data word comes from the approximation register.

A period counter steps once per clock through `2^DATA_W - 1` states and then starts again. Each period opens with the output high, and the output drops once the stored word's number of cycles has passed. The word is captured only at reset and at period boundaries, so a change on the input in the middle of a period never shortens or stretches the pulse in progress. The period-boundary strobe is taken from a flip-flop, not from the counter's compare gates. The compare result cannot glitch onto the output or the holding register.

Top module: `pwm_dac_driver`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter goes to 0 and the word on `din` is captured. In the first cycle after reset is released, `pwm_o` is 1 if that word is non-zero and 0 if it is zero.
- R2: One period lasts exactly `2^DATA_W - 1` clock cycles (15 by default). The internal counter steps by one per clock from 0 up to `2^DATA_W - 2` and then returns to 0.
- R3: In each period, `pwm_o` is high for the first V cycles and low for the remaining cycles, where V is the unsigned value of the captured word.
- R4: A captured word of 0 keeps `pwm_o` low for the whole period, including its first cycle.
- R5: A captured word of `2^DATA_W - 1` keeps `pwm_o` high for every cycle of the period.
- R6: `din` is sampled only at the clock edge that starts a new period (and during reset). A change of `din` inside a period has no effect until the next period.
- R7: The period-start strobe is registered. `pwm_o` rises only in the first cycle of a period, never in the middle of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Unsigned duty word, sampled at period boundaries |
| pwm_o | output | 1 | Registered pulse-width modulated output |

## Verification
The bench sweeps every code from 0 to 15 and counts the high cycles in a full period. A design with an off-by-one compare would show V±1 cycles. A design with a 16-state counter would give a period of the wrong length.

The two end codes get extra attention. For code 0, a design that sets the output before checking for a zero word would leave a one-cycle glitch. For code 15, a design that clears the output at the terminal count would cut one cycle off the full-on case.

A word change is injected a few cycles into a period. A design that samples the input continuously would show a pulse of the wrong width in that period.

Every cycle is also compared against a behavioural model of the period counter. Any rise of the output in mid-period is reported, which catches an unregistered or mistimed start strobe.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  // Number of clock cycles in one PWM period for a given word width.
  function automatic int period_cycles(input int width);
    return (1 << width) - 1;
  endfunction

  // Largest counter value reached before it returns to zero.
  function automatic int last_count(input int width);
    return (1 << width) - 2;
  endfunction

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
  import pwm_dac_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] cnt_nxt,
  output logic              wrap_q
);

  localparam int              LastInt = last_count(DATA_W);
  localparam logic [DATA_W-1:0] LAST  = LastInt[DATA_W-1:0];
  localparam logic [DATA_W-1:0] PRE   = LAST - 1'b1;

  logic pre_wrap_c;

  // Combinational look-ahead: the next count is the terminal one.
  assign pre_wrap_c = (cnt_q == PRE);
  assign cnt_nxt    = wrap_q ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      // Registered strobe: high exactly while the counter sits at LAST.
      wrap_q <= pre_wrap_c;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);                                              // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));          // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));                           // R2
  AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (cnt_q == LAST));                                  // R7

endmodule

// File: rtl/pwm_word_latch.sv
module pwm_word_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold_q
);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      hold_q <= din;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hold_q));                                   // R6

endmodule

// File: rtl/pwm_edge_logic.sv
module pwm_edge_logic #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_q,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic [DATA_W-1:0] cnt_nxt,
  input  logic [DATA_W-1:0] hold_q,
  output logic              pwm_q
);

  localparam logic [DATA_W-1:0] FULL = '1;

  logic start_val_c;
  logic match_c;

  // A period opens high unless the freshly loaded word is zero.
  assign start_val_c = (din != '0);
  // Clear when the count about to be entered reaches the stored word.
  assign match_c     = (cnt_nxt == hold_q);

  always_ff @(posedge clk) begin
    if (rst || wrap_q) begin
      pwm_q <= start_val_c;
    end else if (match_c) begin
      pwm_q <= 1'b0;
    end
  end

  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < hold_q) |-> pwm_q);                                  // R3
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= hold_q) |-> !pwm_q);                                // R3
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    (hold_q == '0) |-> !pwm_q);                                   // R4
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (rst)
    (hold_q == FULL) |-> pwm_q);                                  // R5
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> (cnt_q == '0));                              // R7

endmodule

// File: rtl/pwm_dac_driver.sv
module pwm_dac_driver #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic              pwm_o
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_nxt;
  logic [DATA_W-1:0] hold_q;
  logic              wrap_q;

  pwm_period_counter #(.DATA_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap_q  (wrap_q)
  );

  pwm_word_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load   (wrap_q),
    .din    (din),
    .hold_q (hold_q)
  );

  pwm_edge_logic #(.DATA_W(DATA_W)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .wrap_q  (wrap_q),
    .din     (din),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .hold_q  (hold_q),
    .pwm_q   (pwm_o)
  );

  AST_RESET_OUT: assert property (@(posedge clk)
    rst |=> (pwm_o == ($past(din) != '0)));                       // R1

endmodule

// File: tb/pwm_dac_driver_tb.sv
module pwm_dac_driver_tb;

  localparam int W   = 4;
  localparam int PER = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic         pwm_o;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  int m_hold = 0;
  bit m_live = 0;
  bit prev_pwm = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_dac_driver #(.DATA_W(W)) u_dut (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .pwm_o (pwm_o)
  );

  // Behavioural reference: position in period and captured word.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt  = 0;
      m_hold = int'(din);
      m_live = 1;
    end else if (m_live) begin
      if (m_cnt == PER - 1) begin
        m_cnt  = 0;
        m_hold = int'(din);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (m_live && !rst) begin
      check(pwm_o == (m_cnt < m_hold), "R3 per-cycle", int'(pwm_o), int'(m_cnt < m_hold));
      if (pwm_o && !prev_pwm)
        check(m_cnt == 0, "R7 rise position", m_cnt, 0);
      prev_pwm = pwm_o;
    end
  end

  task automatic wait_start();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  // Count high cycles across one period starting at the current negedge.
  task automatic measure(output int highs);
    highs = 0;
    for (int i = 0; i < PER; i++) begin
      if (pwm_o) highs++;
      if (i < PER - 1) @(negedge clk);
    end
  endtask

  initial begin
    int h;
    int gap;
    din = 4'd5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b1, "R1 reset nonzero", int'(pwm_o), 1);

    rst = 1'b1; din = 4'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R1 reset zero", int'(pwm_o), 0);

    // Sweep of all codes: high time per period.
    for (int code = 0; code < (1 << W); code++) begin
      din = code[W-1:0];
      wait_start();
      measure(h);
      if (code == 0)
        check(h == 0, "R4 zero code", h, 0);
      else if (code == (1 << W) - 1)
        check(h == PER, "R5 full code", h, PER);
      else
        check(h == code, "R3 high time", h, code);
    end

    // Period length: spacing between rising edges for code 6.
    din = 4'd6;
    wait_start();
    @(negedge clk);
    gap = 1;
    while (!(pwm_o && m_cnt == 0)) begin
      @(negedge clk);
      gap++;
    end
    check(gap == PER, "R2 period length", gap, PER);

    // Mid-period change of din.
    din = 4'd2;
    wait_start();
    wait_start();
    h = 0;
    for (int i = 0; i < PER; i++) begin
      if (pwm_o) h++;
      if (i == 1) din = 4'd12;
      if (i < PER - 1) @(negedge clk);
    end
    check(h == 2, "R6 mid-period ignored", h, 2);
    @(negedge clk);
    measure(h);
    check(h == 12, "R6 next period applies", h, 12);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule